// File: doc/BRIEF.md
# Enable-Gated Fractional Pulse Scaler

The block shortens a time window by a programmable fraction. For as long as its enable input is high, every clock edge adds a frequency control word to a modulo-2^RM accumulator. The carry out of that addition is registered and driven out as a single-bit pulse stream. Over an enable window of W cycles the output is high for about FCW·W/2^RM cycles. Any fractional remainder stays in the accumulator and counts toward the next window.

A typical consumer is an up/down counter that integrates the scaled pulses. Two instances, one with a proportional word and one with an integral word, can weight the same up or down window by different gains. While enable is low the accumulator keeps its residue and the output stays low. A synchronous reset returns the block to a zero residue.

Top module: `frac_pulse_scaler`

## Requirements
- R1: The accumulator is RM bits wide, RM is a parameter, and its default value is 10.
- R2: On a clock edge with enable high, the accumulator takes the low RM bits of (accumulator + FCW). The output register takes bit RM of that RM+1-bit sum, which is the carry.
- R3: Over an enable window of W consecutive enabled edges that starts with residue r, the output is high on exactly floor((r + FCW·W) / 2^RM) of the cycles that follow those edges.
- R4: On a clock edge with enable low, the output register is loaded with 0.
- R5: On a clock edge with enable low, the accumulator keeps its value, so the residue left by one window carries into the next one.
- R6: A synchronous active-high reset clears both the accumulator and the output register to 0, and it takes priority over enable.
- R7: While enable is high, FCW lies in the legal range 1 to 2^RM − 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ena | input | 1 | Accumulate enable |
| fcw | input | RM | Frequency control word, the fraction numerator |
| out | output | 1 | Registered carry pulse |

## Verification
The assertions assume that FCW is never zero while enable is high. The carry check also depends on this: with a nonzero word below 2^RM, a carry happens exactly when the accumulator wraps to a smaller value. The stimulus drives only words from 1 to 2^RM − 1 whenever enable is high, and it changes inputs only away from the active edge. The bench sweeps every legal word of a 4-bit configuration through windows of several lengths, idle gaps and resets during enable, and it checks one point on the default 10-bit configuration.

// File: rtl/frac_pulse_scaler_pkg.sv
package frac_pulse_scaler_pkg;
    parameter int unsigned FPS_RM_DEFAULT = 10;
endpackage

// File: rtl/fps_adder.sv
module fps_adder #(
    parameter int unsigned RM = 10
) (
    input  logic [RM-1:0] a_i,
    input  logic [RM-1:0] b_i,
    output logic [RM-1:0] sum_o,
    output logic          carry_o
);
    localparam int unsigned SW = RM + 1;
    logic [SW-1:0] wide;

    always_comb begin
        wide    = {1'b0, a_i} + {1'b0, b_i};
        sum_o   = wide[RM-1:0];
        carry_o = wide[RM];
    end
endmodule

// File: rtl/fps_next.sv
module fps_next #(
    parameter int unsigned RM = 10
) (
    input  logic          rst_i,
    input  logic          ena_i,
    input  logic [RM-1:0] acc_q_i,
    input  logic [RM-1:0] sum_i,
    input  logic          carry_i,
    output logic [RM-1:0] acc_d_o,
    output logic          out_d_o
);
    always_comb begin
        acc_d_o = acc_q_i;
        out_d_o = 1'b0;
        if (rst_i) begin
            acc_d_o = '0;
            out_d_o = 1'b0;
        end else if (ena_i) begin
            acc_d_o = sum_i;
            out_d_o = carry_i;
        end
    end
endmodule

// File: rtl/frac_pulse_scaler.sv
module frac_pulse_scaler
    import frac_pulse_scaler_pkg::*;
#(
    parameter int unsigned RM = FPS_RM_DEFAULT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ena,
    input  logic [RM-1:0] fcw,
    output logic          out
);
    typedef struct packed {
        logic [RM-1:0] acc;
        logic          pulse;
    } fps_state_t;

    fps_state_t st_d, st_q;
    logic [RM-1:0] sum_w;
    logic          carry_w;
    logic [RM-1:0] acc_d_w;
    logic          out_d_w;

    fps_adder #(.RM(RM)) u_add (
        .a_i     (st_q.acc),
        .b_i     (fcw),
        .sum_o   (sum_w),
        .carry_o (carry_w)
    );

    fps_next #(.RM(RM)) u_next (
        .rst_i   (rst),
        .ena_i   (ena),
        .acc_q_i (st_q.acc),
        .sum_i   (sum_w),
        .carry_i (carry_w),
        .acc_d_o (acc_d_w),
        .out_d_o (out_d_w)
    );

    always_comb begin
        st_d.acc   = acc_d_w;
        st_d.pulse = out_d_w;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign out = st_q.pulse;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (st_q.acc == '0 && !out)); // R6

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !ena |=> !out); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ena |=> $stable(st_q.acc)); // R5

    AST_CARRY_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        ena |=> (out == (st_q.acc < $past(st_q.acc)))); // R2

    AST_FCW_LEGAL: assert property (@(posedge clk) disable iff (rst)
        ena |-> (fcw != '0)); // R7
endmodule

// File: tb/frac_pulse_scaler_tb.sv
module frac_pulse_scaler_tb;
    localparam int RMS = 4;
    localparam int MODS = 1 << RMS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ena = 1'b0;
    logic [RMS-1:0] fcw = '0;
    logic out;
    logic ena_w = 1'b0;
    logic [9:0] fcw_w = '0;
    logic out_w;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    frac_pulse_scaler #(.RM(RMS)) u_dut (
        .clk(clk), .rst(rst), .ena(ena), .fcw(fcw), .out(out));

    frac_pulse_scaler u_dut_wide (
        .clk(clk), .rst(rst), .ena(ena_w), .fcw(fcw_w), .out(out_w));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic r, input logic e, input int f);
        rst = r;
        ena = e;
        fcw = f[RMS-1:0];
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int r;
        int cnt;
        int w;
        int exp;
        for (int f = 1; f < MODS; f++) begin
            tick(1'b1, 1'b0, 1);
            chk(out == 1'b0, "R6 reset output", out, 0);
            r = 0;
            for (int pass = 0; pass < 2; pass++) begin
                w = (pass == 0) ? 7 + f % 5 : 5 + f % 3;
                exp = (r + f * w) / MODS;
                cnt = 0;
                for (int k = 0; k < w; k++) begin
                    tick(1'b0, 1'b1, f);
                    // R2: carry of each enabled addition
                    chk(out == ((r + f) >= MODS), "R2 per-edge carry", out, int'((r + f) >= MODS));
                    r = (r + f) % MODS;
                    if (out) cnt++;
                end
                // R3 on the first pass, R5 (residue kept through idle) on the second
                chk(cnt == exp, pass == 0 ? "R3 window pulse count" : "R5 residue carried", cnt, exp);
                for (int k = 0; k < 3; k++) begin
                    tick(1'b0, 1'b0, f);
                    chk(out == 1'b0, "R4 idle output low", out, 0);
                end
            end
            tick(1'b0, 1'b1, f);
            tick(1'b1, 1'b1, f);
            chk(out == 1'b0, "R6 reset beats enable", out, 0);
            cnt = 0;
            for (int k = 0; k < MODS; k++) begin
                tick(1'b0, 1'b1, f);
                if (out) cnt++;
            end
            chk(cnt == f, "R6 residue cleared", cnt, f);
            tick(1'b0, 1'b0, f);
        end

        // R1: default width is 10 bits
        rst = 1'b1;
        @(posedge clk); #2;
        rst = 1'b0;
        cnt = 0;
        ena_w = 1'b1;
        fcw_w = 10'd512;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk); #2;
            if (out_w) cnt++;
        end
        chk(cnt == 4, "R1 default width half word", cnt, 4);
        cnt = 0;
        fcw_w = 10'd1023;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #2;
            if (out_w) cnt++;
        end
        chk(cnt == 2, "R1 default width max word", cnt, 2);
        ena_w = 1'b0;
        @(posedge clk); #2;
        chk(out_w == 1'b0, "R1 R4 default idle", out_w, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule